// File: doc/BRIEF.md
# Pipelined Sample-to-Byte Output Multiplexer

This block sits at the digital edge of a multi-channel image-sensor converter. Each conversion cycle delivers one 16-bit result together with a small tag that names the colour channel it came from. The block holds each result in a fixed-depth delay line so that it leaves the block a set number of conversion cycles after it was taken. It then places the result on an 8-bit bus as two byte slots, upper byte first. In single-byte mode it offers only the upper byte, which is shown in both slots.

The block runs on a byte-slot clock, and one conversion cycle spans two of its edges. An internal slot phase decides on which edge a new result is taken: the "high" edge. A flag marks whether the bus currently carries an upper or a lower byte, and the tag of the result leaves alongside it, so the output follows whatever channel order the sampling sequencer used. An active-low enable releases the bus. A power-down input freezes the whole pipeline and forces the bus to zero, and the held results survive the freeze. Switching the byte mode flushes the pipeline and restarts the slot phase.

Top module: `byte_lane_mux`

## Requirements
- R1: While `rst` is high at a clock edge, the bus value, `hi_byte` and `tag_out` become 0 and every held result is cleared. After reset, the first 9 results emitted are all-zero words with tag 0.
- R2: In two-byte mode (`one_byte`=0), the upper byte `smp_word[15:8]` of a result appears after a high edge, and its lower byte `smp_word[7:0]` appears after the next edge.
- R3: A result taken at a high edge shows its upper byte on the bus right after the 18th following edge, which is 9 conversion cycles later.
- R4: The first edge after reset is a high edge, and high edges then alternate with low edges. Results are taken only at high edges. Values on `smp_word`/`smp_tag` at a low edge have no effect.
- R5: `hi_byte` is 1 while an upper byte is shown and 0 while a lower byte is shown. It toggles on every edge that has neither power-down nor a mode change.
- R6: `tag_out` carries the tag taken with the result being shown. It is held through both of that result's byte slots, so tags leave in the order they arrived.
- R7: In single-byte mode (`one_byte`=1), both byte slots of a result carry its upper byte.
- R8: At an edge where `one_byte` differs from its value at the previous edge, the bus value, `hi_byte` and `tag_out` become 0, all held results are cleared, the sample offered at that edge is dropped, and the next edge is a high edge.
- R9: With `oe_n`=1, `dq_drv` is 0 and `dq` is released to high impedance at once. The internal state is unaffected.
- R10: At an edge with `pd`=1 and no mode change, the bus value becomes 0. The slot phase, `hi_byte`, `tag_out` and all held results stay unchanged, and no sample is taken. When `pd` returns to 0, output resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-slot clock; two edges per conversion cycle |
| rst | input | 1 | Synchronous active-high reset |
| pd | input | 1 | Power-down: freeze pipeline, bus value forced to zero |
| one_byte | input | 1 | 1 = single-byte (upper byte only) output mode |
| oe_n | input | 1 | Active-low output enable |
| smp_word | input | 16 | Conversion result, taken on high edges |
| smp_tag | input | 2 | Channel tag of the result |
| dq | output | 8 | Byte bus, high impedance when disabled |
| dq_drv | output | 1 | High while the block drives `dq` |
| hi_byte | output | 1 | 1 = upper byte on the bus, 0 = lower byte |
| tag_out | output | 2 | Tag of the result on the bus |

## Verification
A slot phase that is off by one edge swaps the upper and lower bytes, and this shows at the next edge. A `hi_byte` that fails to toggle shows within one edge. A delay line with a wrong depth moves a lone marker result by two edges per missing or extra stage, which a single directed result makes plain 18 edges after it was taken. A flush that leaves stale entries lets an in-flight result reappear up to 18 edges after the mode change. A power-down that leaks shows a nonzero bus at the first frozen edge. A freeze that loses state shows a wrong or shifted byte sequence in the first slots after release.

// File: rtl/blm_pkg.sv
package blm_pkg;

  // Which byte the next clock edge will place on the bus.
  typedef enum logic {
    SLOT_HI = 1'b0,
    SLOT_LO = 1'b1
  } slot_e;

  function automatic slot_e next_slot(input slot_e s);
    return (s == SLOT_HI) ? SLOT_LO : SLOT_HI;
  endfunction

endpackage

// File: rtl/blm_phase.sv
module blm_phase
  import blm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pd,
  input  logic  one_byte,
  output slot_e slot,
  output logic  flush
);

  logic mode_q;

  // A mode change is seen as a difference from the mode held at the last edge.
  assign flush = (one_byte != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= SLOT_HI;
      mode_q <= one_byte;
    end else if (flush) begin
      slot   <= SLOT_HI;
      mode_q <= one_byte;
    end else if (!pd) begin
      slot   <= next_slot(slot);
    end
  end

  // R8
  flush_restart_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (slot == SLOT_HI));

  // R10
  pd_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pd && !flush) |=> $stable(slot));

  // R4
  phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd && !flush) |=> (slot != $past(slot)));

endmodule

// File: rtl/blm_delay.sv
module blm_delay #(
  parameter int DW  = 16,
  parameter int TW  = 2,
  parameter int LAT = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [DW-1:0] in_word,
  input  logic [TW-1:0] in_tag,
  output logic [DW-1:0] out_word,
  output logic [TW-1:0] out_tag
);

  localparam int EW = DW + TW;

  logic [LAT-1:0][EW-1:0] stg;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clr)  stg[0] <= '0;
        else if (adv)    stg[0] <= {in_tag, in_word};
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          stg <= '0;
        end else if (adv) begin
          stg[0] <= {in_tag, in_word};
          for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign out_word = stg[LAT-1][DW-1:0];
  assign out_tag  = stg[LAT-1][EW-1:DW];

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(stg[LAT-1]));

  // R8
  clear_tail_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (out_word == '0 && out_tag == '0));

endmodule

// File: rtl/blm_outstage.sv
module blm_outstage
  import blm_pkg::*;
#(
  parameter int BW = 8,
  parameter int TW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            pd,
  input  slot_e           slot,
  input  logic            one_byte,
  input  logic [2*BW-1:0] ent_word,
  input  logic [TW-1:0]   ent_tag,
  output logic [BW-1:0]   bus_q,
  output logic            hl_q,
  output logic [TW-1:0]   tag_q
);

  logic [BW-1:0] hi_hold;
  logic [BW-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bus_q   <= '0;
      hl_q    <= 1'b0;
      tag_q   <= '0;
      hi_hold <= '0;
      lo_hold <= '0;
    end else if (pd) begin
      bus_q   <= '0;
    end else if (slot == SLOT_HI) begin
      bus_q   <= ent_word[2*BW-1:BW];
      hi_hold <= ent_word[2*BW-1:BW];
      lo_hold <= ent_word[BW-1:0];
      tag_q   <= ent_tag;
      hl_q    <= 1'b1;
    end else begin
      bus_q   <= one_byte ? hi_hold : lo_hold;
      hl_q    <= 1'b0;
    end
  end

  // R10
  pd_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pd && !clr) |=> (bus_q == '0));

  // R8
  flush_out_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bus_q == '0 && !hl_q && tag_q == '0));

  // R6
  tag_hold_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd && !clr && slot == SLOT_LO) |=> $stable(tag_q));

endmodule

// File: rtl/byte_lane_mux.sv
module byte_lane_mux
  import blm_pkg::*;
#(
  parameter int BW  = 8,
  parameter int TW  = 2,
  parameter int LAT = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd,
  input  logic            one_byte,
  input  logic            oe_n,
  input  logic [2*BW-1:0] smp_word,
  input  logic [TW-1:0]   smp_tag,
  output logic [BW-1:0]   dq,
  output logic            dq_drv,
  output logic            hi_byte,
  output logic [TW-1:0]   tag_out
);

  localparam int DW = 2 * BW;

  slot_e         slot;
  logic          flush;
  logic          adv;
  logic [DW-1:0] tail_word;
  logic [TW-1:0] tail_tag;
  logic [BW-1:0] bus_q;

  blm_phase u_phase (
    .clk      (clk),
    .rst      (rst),
    .pd       (pd),
    .one_byte (one_byte),
    .slot     (slot),
    .flush    (flush)
  );

  assign adv = (slot == SLOT_HI) && !pd && !flush;

  blm_delay #(.DW(DW), .TW(TW), .LAT(LAT)) u_delay (
    .clk      (clk),
    .rst      (rst),
    .clr      (flush),
    .adv      (adv),
    .in_word  (smp_word),
    .in_tag   (smp_tag),
    .out_word (tail_word),
    .out_tag  (tail_tag)
  );

  blm_outstage #(.BW(BW), .TW(TW)) u_out (
    .clk      (clk),
    .rst      (rst),
    .clr      (flush),
    .pd       (pd),
    .slot     (slot),
    .one_byte (one_byte),
    .ent_word (tail_word),
    .ent_tag  (tail_tag),
    .bus_q    (bus_q),
    .hl_q     (hi_byte),
    .tag_q    (tag_out)
  );

  assign dq_drv = !oe_n;
  assign dq     = oe_n ? {BW{1'bz}} : bus_q;

  // R5
  hl_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (!pd && !flush) |=> (hi_byte != $past(hi_byte)));

  // R10
  pd_hl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pd && !flush) |=> ($stable(hi_byte) && $stable(tag_out)));

endmodule

// File: tb/byte_lane_mux_bench.sv
`timescale 1ns/1ps
module byte_lane_mux_bench;

  localparam int BW  = 8;
  localparam int TW  = 2;
  localparam int LAT = 9;
  localparam int DW  = 2 * BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pd = 1'b0;
  logic          one_byte = 1'b0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] word = '0;
  logic [TW-1:0] tag = '0;
  wire  [BW-1:0] dq;
  wire           dq_drv;
  wire           hi_byte;
  wire  [TW-1:0] tag_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byte_lane_mux #(.BW(BW), .TW(TW), .LAT(LAT)) u_byte_lane_mux (
    .clk(clk), .rst(rst), .pd(pd), .one_byte(one_byte), .oe_n(oe_n),
    .smp_word(word), .smp_tag(tag), .dq(dq), .dq_drv(dq_drv),
    .hi_byte(hi_byte), .tag_out(tag_out)
  );

  // Reference model, written from the requirements
  logic [DW+TW-1:0] m_pipe [LAT];
  logic             m_slot;   // 0: next edge is high
  logic             m_mode;
  logic [BW-1:0]    m_bus, m_hih, m_loh;
  logic             m_hl;
  logic [TW-1:0]    m_tag;
  bit               m_flushed;

  task automatic model_clear();
    for (int i = 0; i < LAT; i++) m_pipe[i] = '0;
    m_slot = 1'b0; m_mode = one_byte;
    m_bus = '0; m_hih = '0; m_loh = '0; m_hl = 1'b0; m_tag = '0;
  endtask

  task automatic model_edge();
    logic [DW+TW-1:0] ent;
    m_flushed = 1'b0;
    if (rst) begin
      model_clear();
    end else if (one_byte != m_mode) begin
      model_clear();
      m_flushed = 1'b1;
    end else if (pd) begin
      m_bus = '0;
    end else if (m_slot == 1'b0) begin
      ent = m_pipe[LAT-1];
      m_bus = ent[DW-1:BW]; m_hih = ent[DW-1:BW]; m_loh = ent[BW-1:0];
      m_tag = ent[DW+TW-1:DW]; m_hl = 1'b1;
      for (int i = LAT-1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = {tag, word};
      m_slot = 1'b1;
    end else begin
      m_bus = one_byte ? m_hih : m_loh;
      m_hl = 1'b0;
      m_slot = 1'b0;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_model();
    string breq;
    breq = m_flushed ? "R8" : (pd ? "R10" : (one_byte ? "R7" : "R2"));
    check("R9", "dq_drv", int'(dq_drv), int'(!oe_n));
    if (!oe_n) check(breq, "bus", int'(dq), int'(m_bus));
    check(m_flushed ? "R8" : "R5", "hi_byte", int'(hi_byte), int'(m_hl));
    check(m_flushed ? "R8" : "R6", "tag_out", int'(tag_out), int'(m_tag));
  endtask

  // One clock edge: inputs already set, sample 1 ns after the edge
  task automatic step();
    @(posedge clk);
    #1;
    model_edge();
    compare_model();
  endtask

  task automatic drive(logic [DW-1:0] w, logic [TW-1:0] t);
    word = w; tag = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    // R1: reset state
    rst = 1'b1; drive(16'hDEAD, 2'd3);
    repeat (3) step();
    check("R1", "reset bus", int'(dq), 0);
    check("R1", "reset hi_byte", int'(hi_byte), 0);
    check("R1", "reset tag", int'(tag_out), 0);
    rst = 1'b0;

    // R3/R4/R2: directed latency, low-edge input ignored
    for (int n = 0; n <= 21; n++) begin
      case (n)
        0: drive(16'hA5C3, 2'd2);
        1: drive(16'hFFFF, 2'd3);
        2: drive(16'h1234, 2'd1);
        default: drive(16'h0000, 2'd0);
      endcase
      step();
      if (n == 16) begin
        check("R1", "warm-up word zero", int'(dq), 0);
        check("R1", "warm-up tag zero", int'(tag_out), 0);
      end
      if (n == 17) check("R3", "no early byte", int'(dq), 0);
      if (n == 18) begin
        check("R3", "high byte at 18 edges", int'(dq), 16'hA5);
        check("R5", "high flag", int'(hi_byte), 1);
        check("R6", "tag with high", int'(tag_out), 2);
      end
      if (n == 19) begin
        check("R2", "low byte follows", int'(dq), 16'hC3);
        check("R5", "low flag", int'(hi_byte), 0);
        check("R6", "tag held on low", int'(tag_out), 2);
      end
      if (n == 20) begin
        check("R4", "low-edge input ignored", int'(dq), 16'h12);
        check("R6", "next tag", int'(tag_out), 1);
      end
      if (n == 21) check("R2", "second low byte", int'(dq), 16'h34);
    end

    // R8 flush with result in flight, then R7 single-byte
    drive(16'h7788, 2'd1); step();           // edge 22, high
    drive(16'h0000, 2'd0); one_byte = 1'b1; step();   // edge 23, flush
    check("R8", "flush bus", int'(dq), 0);
    check("R8", "flush hi_byte", int'(hi_byte), 0);
    check("R8", "flush tag", int'(tag_out), 0);
    drive(16'hBEEF, 2'd3); step();           // edge 24, high
    check("R8", "first edge after flush is high", int'(hi_byte), 1);
    drive(16'h0000, 2'd0);
    for (int n = 25; n <= 43; n++) begin
      step();
      if (n == 40 || n == 41) check("R8", "in-flight result dropped", int'(dq), 0);
      if (n == 42) check("R7", "single-byte high slot", int'(dq), 16'hBE);
      if (n == 43) check("R7", "single-byte repeats upper", int'(dq), 16'hBE);
    end

    // R10 directed freeze
    one_byte = 1'b0; step();
    for (int n = 0; n < 6; n++) begin drive(16'h1111 * (n + 1), 2'(n)); step(); end
    pd = 1'b1; drive(16'hCAFE, 2'd2);
    for (int n = 0; n < 5; n++) begin
      step();
      check("R10", "bus zero in power-down", int'(dq), 0);
    end
    pd = 1'b0;

    // R9 directed release
    oe_n = 1'b1; step();
    check("R9", "bus released", int'(dq_drv), 0);
    oe_n = 1'b0;

    // Random phase
    for (int n = 0; n < 6000; n++) begin
      drive(16'($urandom), 2'($urandom));
      if ($urandom_range(99) < 4) pd = ~pd;
      oe_n = ($urandom_range(99) < 10);
      if ($urandom_range(199) == 0) one_byte = ~one_byte;
      step();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule